// File: doc/BRIEF.md
# DRAM Page-Mode Strobe Sequencer

This block produces the row and column strobe waveform for one access to a page-mode or EDO DRAM bank that has already been selected. An access is either one beat or a four-beat page-mode burst. When a start request is accepted, the block asserts the active-low row strobe and waits a programmed delay. It then asserts the active-low column strobe once per beat. The first beat and the later beats have separate programmed widths, and a programmed precharge gap separates the beats.

Each beat ends with a one-clock data strobe. The column offset steps to the next beat after each beat. After the last beat the column strobe is released, the row strobe follows one clock later, and a one-clock done pulse marks the return to idle. The block checks the timing fields before it starts. If they are illegal, it raises a one-clock configuration error and does not touch the strobes.

Top module: `pgdram_strobe_seq`

## Requirements
- R1: After reset, `ras_n_o` and `cas_n_o` are 1, and `data_stb_o`, `done_o`, `cfg_err_o` and `col_sel_o` are 0.
- R2: `timing_i` holds four 3-bit fields: RAS-to-CAS delay in [2:0], first CAS width in [5:3], page CAS width in [8:6] and precharge gap in [11:9]. If start is accepted at a clock edge, `ras_n_o` is 0 from the next cycle, and `cas_n_o` first goes to 0 exactly D cycles later, where D is the decoded delay.
- R3: Each field decodes code k in 1..7 to k clocks and code 0 to 8 clocks.
- R4: A delay code of 1 is reserved. A start request in idle with that code gives `cfg_err_o` = 1 for exactly the next cycle, and `ras_n_o` stays 1.
- R5: For a single access, and for beat 0 of a burst, `cas_n_o` stays 0 for the decoded first-width clocks.
- R6: For beats 1 to 3 of a burst (`burst_i` = 1), `cas_n_o` stays 0 for the decoded page-width clocks.
- R7: Between the beats of a burst, `cas_n_o` stays 1 for the decoded precharge clocks.
- R8: With `ecc_en_i` = 1, a start request whose decoded page width plus precharge is not 4 is refused with `cfg_err_o`, as in R4. When the sum is 4, the access runs normally.
- R9: `data_stb_o` is 1 only in the last cycle of each CAS assertion. During beat b, `col_beat_o` equals b, and `col_sel_o` is 1 from the first CAS cycle until the row strobe is released.
- R10: After the last beat, one cycle follows with `cas_n_o` = 1 and `ras_n_o` = 0. In the next cycle `ras_n_o` = 1 and `done_o` = 1 for that single cycle.
- R11: The fields, `burst_i` and `ecc_en_i` are captured when start is accepted. Changing them, or asserting `start_i`, while an access runs has no effect on that access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Access request, taken only when idle |
| burst_i | input | 1 | 1 = four-beat burst, 0 = single beat |
| ecc_en_i | input | 1 | Enables the page+precharge = 4 rule |
| timing_i | input | 12 | Packed timing fields (see R2) |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| col_sel_o | output | 1 | Column address selected on the address mux |
| col_beat_o | output | 2 | Column offset of the current beat |
| data_stb_o | output | 1 | One-clock data strobe per beat |
| done_o | output | 1 | One-clock end-of-access pulse |
| cfg_err_o | output | 1 | One-clock refusal of an illegal start |

## Verification
Single accesses sweep every legal delay code against every first-width code. This separates the delay decode from the first-width decode, including the 000-means-8 case on each field. Bursts sweep every page-width code against every precharge code, with the delay and first width varied by formula, so a swap between the page and first widths, or between the width and the gap, shows up as a shifted window. Half of all accesses also toggle start and scramble the fields in mid-access, which exposes any field that is not captured. An ECC sweep over all page/precharge pairs tells the three legal sums apart from the refused ones, and reserved-delay requests confirm that no row strobe appears.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RCD  = 3'd1,
        ST_CAS  = 3'd2,
        ST_PRE  = 3'd3,
        ST_TAIL = 3'd4
    } seq_state_e;

    // field slots inside the packed timing word
    localparam int unsigned FLD_RCD   = 0;
    localparam int unsigned FLD_FIRST = 1;
    localparam int unsigned FLD_PAGE  = 2;
    localparam int unsigned FLD_PRE   = 3;
    localparam int unsigned NUM_FIELDS = 4;

endpackage

// File: rtl/pgdram_field_decode.sv
// Turns a timing code into a down-counter reload value.
// Code k means k clocks, code 0 means 2**W clocks; the reload is clocks-1,
// which is exactly code-1 taken modulo 2**W.
module pgdram_field_decode #(
    parameter int FIELD_W = 3
) (
    input  logic [FIELD_W-1:0] code_i,
    output logic [FIELD_W-1:0] reload_o
);
    localparam logic [FIELD_W-1:0] ONE = FIELD_W'(1);

    always_comb begin
        reload_o = code_i - ONE;
    end
endmodule

// File: rtl/pgdram_cfg_check.sv
// Flags illegal timing before an access is started.
module pgdram_cfg_check #(
    parameter int FIELD_W = 3,
    parameter int ECC_SUM = 4
) (
    input  logic               ecc_en_i,
    input  logic [FIELD_W-1:0] rcd_reload_i,
    input  logic [FIELD_W-1:0] page_reload_i,
    input  logic [FIELD_W-1:0] pre_reload_i,
    output logic               bad_o
);
    // clocks = reload + 1 on both fields, so the sum rule becomes reload sum == ECC_SUM-2
    localparam logic [FIELD_W:0] RELOAD_SUM = (FIELD_W+1)'(ECC_SUM - 2);

    logic               rcd_reserved;
    logic               ecc_bad;
    logic [FIELD_W:0]   reload_sum;

    always_comb begin
        rcd_reserved = (rcd_reload_i == '0);   // code 1 -> one clock, reserved
        reload_sum   = {1'b0, page_reload_i} + {1'b0, pre_reload_i};
        ecc_bad      = ecc_en_i && (reload_sum != RELOAD_SUM);
        bad_o        = rcd_reserved || ecc_bad;
    end
endmodule

// File: rtl/pgdram_seq_fsm.sv
module pgdram_seq_fsm
    import pgdram_pkg::*;
#(
    parameter int FIELD_W = 3,
    parameter int BEATS   = 4,
    parameter int BEAT_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               burst_i,
    input  logic               bad_cfg_i,
    input  logic [FIELD_W-1:0] rcd_reload_i,
    input  logic [FIELD_W-1:0] first_reload_i,
    input  logic [FIELD_W-1:0] page_reload_i,
    input  logic [FIELD_W-1:0] pre_reload_i,
    output logic               ras_n_o,
    output logic               cas_n_o,
    output logic               col_sel_o,
    output logic [BEAT_W-1:0]  col_beat_o,
    output logic               data_stb_o,
    output logic               done_o,
    output logic               cfg_err_o,
    output logic               busy_o
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    typedef struct packed {
        seq_state_e         st;
        logic [FIELD_W-1:0] cnt;
        logic [BEAT_W-1:0]  beat;
        logic               multi;
        logic [FIELD_W-1:0] first;
        logic [FIELD_W-1:0] page;
        logic [FIELD_W-1:0] pre;
        logic               done;
        logic               err;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.err  = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (bad_cfg_i) begin
                        seq_d.err = 1'b1;
                    end else begin
                        seq_d.st    = ST_RCD;
                        seq_d.cnt   = rcd_reload_i;
                        seq_d.beat  = '0;
                        seq_d.multi = burst_i;
                        seq_d.first = first_reload_i;
                        seq_d.page  = page_reload_i;
                        seq_d.pre   = pre_reload_i;
                    end
                end
            end
            ST_RCD: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st  = ST_CAS;
                    seq_d.cnt = seq_q.first;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_CAS: begin
                if (seq_q.cnt == '0) begin
                    if (seq_q.multi && (seq_q.beat != LAST_BEAT)) begin
                        seq_d.st   = ST_PRE;
                        seq_d.cnt  = seq_q.pre;
                        seq_d.beat = seq_q.beat + 1'b1;
                    end else begin
                        seq_d.st = ST_TAIL;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_PRE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st  = ST_CAS;
                    seq_d.cnt = seq_q.page;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_TAIL: begin
                seq_d.st   = ST_IDLE;
                seq_d.done = 1'b1;
            end
            default: begin
                seq_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    always_comb begin
        ras_n_o    = (seq_q.st == ST_IDLE);
        cas_n_o    = (seq_q.st != ST_CAS);
        col_sel_o  = (seq_q.st == ST_CAS) || (seq_q.st == ST_PRE) || (seq_q.st == ST_TAIL);
        col_beat_o = seq_q.beat;
        data_stb_o = (seq_q.st == ST_CAS) && (seq_q.cnt == '0);
        done_o     = seq_q.done;
        cfg_err_o  = seq_q.err;
        busy_o     = (seq_q.st != ST_IDLE);
    end
endmodule

// File: rtl/pgdram_strobe_seq.sv
module pgdram_strobe_seq
    import pgdram_pkg::*;
#(
    parameter  int FIELD_W = 3,
    parameter  int BEATS   = 4,
    parameter  int ECC_SUM = 4,
    localparam int BEAT_W  = (BEATS > 1) ? $clog2(BEATS) : 1,
    localparam int TIME_W  = NUM_FIELDS * FIELD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              burst_i,
    input  logic              ecc_en_i,
    input  logic [TIME_W-1:0] timing_i,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              col_sel_o,
    output logic [BEAT_W-1:0] col_beat_o,
    output logic              data_stb_o,
    output logic              done_o,
    output logic              cfg_err_o
);
    logic [FIELD_W-1:0] reload [NUM_FIELDS];
    logic               bad_cfg;
    logic               busy;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        pgdram_field_decode #(.FIELD_W(FIELD_W)) u_dec (
            .code_i   (timing_i[f*FIELD_W +: FIELD_W]),
            .reload_o (reload[f])
        );
    end

    pgdram_cfg_check #(.FIELD_W(FIELD_W), .ECC_SUM(ECC_SUM)) u_cfg (
        .ecc_en_i      (ecc_en_i),
        .rcd_reload_i  (reload[FLD_RCD]),
        .page_reload_i (reload[FLD_PAGE]),
        .pre_reload_i  (reload[FLD_PRE]),
        .bad_o         (bad_cfg)
    );

    pgdram_seq_fsm #(.FIELD_W(FIELD_W), .BEATS(BEATS), .BEAT_W(BEAT_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .burst_i        (burst_i),
        .bad_cfg_i      (bad_cfg),
        .rcd_reload_i   (reload[FLD_RCD]),
        .first_reload_i (reload[FLD_FIRST]),
        .page_reload_i  (reload[FLD_PAGE]),
        .pre_reload_i   (reload[FLD_PRE]),
        .ras_n_o        (ras_n_o),
        .cas_n_o        (cas_n_o),
        .col_sel_o      (col_sel_o),
        .col_beat_o     (col_beat_o),
        .data_stb_o     (data_stb_o),
        .done_o         (done_o),
        .cfg_err_o      (cfg_err_o),
        .busy_o         (busy)
    );
endmodule

// File: rtl/pgdram_strobe_seq_chk.sv
module pgdram_strobe_seq_chk #(
    parameter int FIELD_W = 3,
    parameter int TIME_W  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [TIME_W-1:0] timing_i,
    input logic              ras_n_o,
    input logic              cas_n_o,
    input logic              col_sel_o,
    input logic              data_stb_o,
    input logic              done_o,
    input logic              cfg_err_o,
    input logic              busy
);
    localparam logic [FIELD_W-1:0] RSV_CODE = FIELD_W'(1);

    AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n_o |-> !ras_n_o);  // R2

    AST_RESERVED_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy && timing_i[FIELD_W-1:0] == RSV_CODE) |=> (cfg_err_o && ras_n_o));  // R4

    AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> (ras_n_o && cas_n_o && !done_o));  // R4

    AST_STB_IN_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb_o |-> (!cas_n_o && col_sel_o));  // R9

    AST_STB_ENDS_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb_o |=> cas_n_o);  // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);  // R10

    AST_RAS_AFTER_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n_o) |-> ($past(cas_n_o) && cas_n_o && done_o));  // R10
endmodule

bind pgdram_strobe_seq pgdram_strobe_seq_chk #(.FIELD_W(FIELD_W), .TIME_W(TIME_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .timing_i   (timing_i),
    .ras_n_o    (ras_n_o),
    .cas_n_o    (cas_n_o),
    .col_sel_o  (col_sel_o),
    .data_stb_o (data_stb_o),
    .done_o     (done_o),
    .cfg_err_o  (cfg_err_o),
    .busy       (busy)
);

// File: tb/pgdram_strobe_seq_tb.sv
module pgdram_strobe_seq_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        burst_i = 1'b0;
    logic        ecc_en_i = 1'b0;
    logic [11:0] timing_i = '0;
    logic        ras_n_o, cas_n_o, col_sel_o, data_stb_o, done_o, cfg_err_o;
    logic [1:0]  col_beat_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgdram_strobe_seq u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .burst_i    (burst_i),
        .ecc_en_i   (ecc_en_i),
        .timing_i   (timing_i),
        .ras_n_o    (ras_n_o),
        .cas_n_o    (cas_n_o),
        .col_sel_o  (col_sel_o),
        .col_beat_o (col_beat_o),
        .data_stb_o (data_stb_o),
        .done_o     (done_o),
        .cfg_err_o  (cfg_err_o)
    );

    function automatic int clocks_of(int code);
        return (code == 0) ? 8 : code;   // R3
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Runs one legal access, comparing every cycle with the arithmetic waveform.
    task automatic run_access(int rc, int fc, int pc, int gc, bit burst, bit ecc, bit mangle);
        int r = clocks_of(rc);
        int f = clocks_of(fc);
        int p = clocks_of(pc);
        int g = clocks_of(gc);
        int n = burst ? 4 : 1;
        int endt = r + f + (n - 1) * (g + p) + 1;
        bit bad_ras = 0, bad_cas = 0, bad_stb = 0, bad_done = 0, bad_sel = 0;
        int a_ras = 0, e_ras = 0, a_cas = 0, e_cas = 0, a_stb = 0, e_stb = 0;
        int a_done = 0, e_done = 0, a_sel = 0, e_sel = 0, bad_t = 0;
        string tag_cas = "R5";
        @(negedge clk);
        timing_i = {3'(gc), 3'(pc), 3'(fc), 3'(rc)};
        burst_i  = burst;
        ecc_en_i = ecc;
        start_i  = 1'b1;
        for (int t = 1; t <= endt + 1; t++) begin
            int b_exp = -1;
            int w_end = 0;
            bit cas_low, stb_exp, sel_exp;
            @(negedge clk);
            if (t >= r + 1 && t <= r + f) begin
                b_exp = 0;
                w_end = r + f;
            end
            for (int b = 1; b < n; b++) begin
                int s = r + f + (b - 1) * (g + p) + g + 1;
                if (t >= s && t < s + p) begin
                    b_exp = b;
                    w_end = s + p - 1;
                end
            end
            cas_low = (b_exp >= 0);
            stb_exp = cas_low && (t == w_end);
            sel_exp = (t > r) && (t <= endt);
            if (!bad_ras && ((ras_n_o != (t > endt)) || cfg_err_o)) begin
                bad_ras = 1; a_ras = ras_n_o; e_ras = (t > endt); bad_t = t;
            end
            if (!bad_cas && (cas_n_o != !cas_low)) begin
                bad_cas = 1; a_cas = cas_n_o; e_cas = !cas_low;
                tag_cas = (t <= r) ? "R2" : (b_exp == 0 || t <= r + f) ? "R5" :
                          (b_exp > 0) ? "R6" : (t < endt) ? "R7" : "R10";
            end
            if (!bad_stb && ((data_stb_o != stb_exp) ||
                             (cas_low && (int'(col_beat_o) != b_exp)))) begin
                bad_stb = 1; a_stb = {data_stb_o, col_beat_o}; e_stb = {stb_exp, 2'(b_exp)};
            end
            if (!bad_sel && (col_sel_o != sel_exp)) begin
                bad_sel = 1; a_sel = col_sel_o; e_sel = sel_exp;
            end
            if (!bad_done && (done_o != (t == endt + 1))) begin
                bad_done = 1; a_done = done_o; e_done = (t == endt + 1);
            end
            // R11: busy-time start pulses and scrambled fields
            if (t == 1) start_i = mangle;
            if (t == 2 && mangle) begin
                timing_i = ~timing_i;
                burst_i  = ~burst_i;
                ecc_en_i = ~ecc_en_i;
            end
            if (t == 3) start_i = 1'b0;
        end
        start_i = 1'b0;
        check(!bad_ras, mangle ? "R2 ras window (R11 mangled)" : "R2 ras window", a_ras, e_ras);
        check(!bad_cas, mangle ? {tag_cas, " cas window (R11 mangled)"} : {tag_cas, " cas window R3"}, a_cas, e_cas);
        check(!bad_stb, "R9 strobe/beat {stb,beat}", a_stb, e_stb);
        check(!bad_sel, "R9 column select", a_sel, e_sel);
        check(!bad_done, "R10 done pulse", a_done, e_done);
        if (bad_ras) $display("  (ras mismatch at t=%0d codes %0d %0d %0d %0d)", bad_t, rc, fc, pc, gc);
    endtask

    // Issues a start that must be refused.
    task automatic run_refused(int rc, int fc, int pc, int gc, bit burst, bit ecc, string req);
        @(negedge clk);
        timing_i = {3'(gc), 3'(pc), 3'(fc), 3'(rc)};
        burst_i  = burst;
        ecc_en_i = ecc;
        start_i  = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(cfg_err_o == 1'b1 && ras_n_o == 1'b1, req, {cfg_err_o, ras_n_o}, 3);
        @(negedge clk);
        check(cfg_err_o == 1'b0 && ras_n_o == 1'b1 && cas_n_o == 1'b1, req,
              {cfg_err_o, ras_n_o, cas_n_o}, 3);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        // R1: outputs while reset is held and just after release
        check(ras_n_o && cas_n_o && !data_stb_o && !done_o && !cfg_err_o && !col_sel_o,
              "R1 reset state", {ras_n_o, cas_n_o, data_stb_o, done_o, cfg_err_o, col_sel_o}, 48);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(ras_n_o && cas_n_o && !data_stb_o && !done_o && !cfg_err_o && !col_sel_o,
              "R1 idle after reset", {ras_n_o, cas_n_o, data_stb_o, done_o, cfg_err_o, col_sel_o}, 48);

        // R2 R3 R5: singles over every legal delay code x first width code
        for (int rc = 0; rc < 8; rc++) begin
            if (rc == 1) continue;
            for (int fc = 0; fc < 8; fc++) begin
                run_access(rc, fc, (rc + fc) % 8, 7 - fc, 1'b0, 1'b0, fc[0]);
            end
        end

        // R6 R7 R9: bursts over every page width x precharge code
        for (int pc = 0; pc < 8; pc++) begin
            for (int gc = 0; gc < 8; gc++) begin
                int rc = (pc + gc) % 7;
                if (rc == 1) rc = 0;
                run_access(rc, (pc * 3 + gc) % 8, pc, gc, 1'b1, 1'b0, gc[0] ^ pc[0]);
            end
        end

        // R4: reserved delay code refused in both modes
        for (int fc = 0; fc < 8; fc++) begin
            run_refused(1, fc, 2, 2, fc[0], 1'b0, "R4 reserved delay code");
        end

        // R8: ECC rule over every page x precharge pair
        for (int pc = 0; pc < 8; pc++) begin
            for (int gc = 0; gc < 8; gc++) begin
                if (clocks_of(pc) + clocks_of(gc) == 4)
                    run_access(3, pc, pc, gc, 1'b1, 1'b1, 1'b0);
                else
                    run_refused(3, 2, pc, gc, 1'b1, 1'b1, "R8 ecc sum refused");
            end
        end

        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule